// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits in front of an interrupt controller and turns a set of external interrupt pins into per-channel "set request" signals. Each channel owns an 8-bit control register that software writes through a simple write port. The register chooses between level detection and edge detection and sets which polarity counts as active. Every pin is first brought into the clock domain by a multi-stage synchronizer. Detection then runs on the synchronized value.

One channel can take its request from a group of key inputs instead of its own pin. A two-bit source field in that channel's register selects the source: the pin, a narrow group of keys, or the whole key group. One channel's register is write-protected. It keeps its reset contents until an external unlock level is high. The full contents of every control register can be read back on a flat output bus. Priority and vectoring are left to the controller downstream.

Top module: `ext_irq_cond`

## Requirements
- R1: After reset every control register reads 0x00 and no set request is active.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the register of channel `wr_ch_i`, which reads back on `ctrl_rd_o[8*ch +: 8]` from the next cycle on. A write to a channel index of NUM_CH or above changes no register.
- R3: With bit 5 of a channel's register at 1 (level mode), the set request is high on every cycle while the input is active. With bit 4 (polarity) at 0 the input is active when high, and with bit 4 at 1 it is active when low.
- R4: With bit 5 at 0 (edge mode), polarity 0 reacts to a high-to-low transition and polarity 1 to a low-to-high transition. Each qualifying transition gives exactly one single-cycle request pulse. The opposite transition gives none.
- R5: An input change first affects the request in the cycle after the second rising clock edge that follows it. It does not affect the request after the first edge.
- R6: On the key channel (default channel 3), register bits 7:6 select the source: 00 selects its own pin, 10 selects keys 3 to 0, and 11 selects keys 4 to 0. Unselected inputs have no effect.
- R7: Polarity is applied to each selected key separately, and the results are ORed. Any single active key raises the request. In edge mode a qualifying transition on any selected key gives a pulse.
- R8: With the reserved source code 01 in bits 7:6, the key channel produces no requests.
- R9: The register of the locked channel (default channel 4) ignores writes while `unlock_i` is low and accepts them while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_CH | External interrupt pins, one per channel |
| key_i | input | NUM_KEY | Key inputs for the key channel |
| unlock_i | input | 1 | Write permission for the locked channel's register |
| wr_en_i | input | 1 | Control register write strobe |
| wr_ch_i | input | CH_W | Channel index of the write |
| wr_data_i | input | 8 | Control register write data |
| set_req_o | output | NUM_CH | Per-channel request-bit set signal |
| ctrl_rd_o | output | 8*NUM_CH | Readback of all control registers, channel 0 in the low byte |

## Verification
The embedded assertions check four properties on every cycle. An edge-mode pulse on a single-pin channel lasts exactly one cycle while the polarity is unchanged. The reserved source code keeps the key channel silent. A write to the locked register while it is locked leaves that register unchanged. A write to an out-of-range channel leaves all readback unchanged. The remaining behaviour can only be shown by the bench's scenarios: the exact two-edge synchronizer latency, the polarity and mode combinations on real pin transitions, the narrow and wide key groups with OR combining, and the continuous level request.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int CTRL_W  = 8;
   localparam int POL_BIT = 4;
   localparam int LVL_BIT = 5;
   localparam int SRC_LO  = 6;
   localparam int SRC_HI  = 7;

   typedef enum logic [1:0] {
      SRC_PIN        = 2'b00,
      SRC_RSVD       = 2'b01,
      SRC_KEY_NARROW = 2'b10,
      SRC_KEY_WIDE   = 2'b11
   } src_sel_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] async_i,
   output logic [W-1:0] sync_o
);
   logic [W-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      end else begin
         stage_q[0] <= async_i;
         for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_keysel.sv
module ext_irq_keysel
   import ext_irq_pkg::*;
#(
   parameter int NUM_KEY    = 5,
   parameter int KEY_NARROW = 4
) (
   input  src_sel_e         sel_i,
   output logic [NUM_KEY:0] mask_o
);
   assign mask_o[0] = (sel_i == SRC_PIN);

   for (genvar k = 0; k < NUM_KEY; k++) begin : g_key
      if (k < KEY_NARROW) begin : g_narrow
         assign mask_o[k+1] = (sel_i == SRC_KEY_NARROW) || (sel_i == SRC_KEY_WIDE);
      end else begin : g_wide
         assign mask_o[k+1] = (sel_i == SRC_KEY_WIDE);
      end
   end
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
   parameter int W = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] in_i,
   input  logic [W-1:0] mask_i,
   input  logic         pol_i,
   input  logic         lvl_i,
   output logic         req_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= in_i;
   end

   always_comb begin
      if (lvl_i)      hit = pol_i ? ~in_i : in_i;
      else if (pol_i) hit = ~prev_q & in_i;
      else            hit = prev_q & ~in_i;
   end

   assign req_o = |(hit & mask_i);

   if (W == 1) begin : g_single_chk
      // R4: an edge pulse lasts one cycle while polarity is held
      a_r4_edge_single: assert property (@(posedge clk) disable iff (!rst_n)
         (!lvl_i && req_o) |=> (lvl_i || (pol_i != $past(pol_i)) || !req_o));
   end
endmodule

// File: rtl/ext_irq_cond.sv
module ext_irq_cond
   import ext_irq_pkg::*;
#(
   parameter int NUM_CH      = 5,
   parameter int NUM_KEY     = 5,
   parameter int KEY_NARROW  = 4,
   parameter int KEY_CH      = 3,
   parameter int LOCK_CH     = 4,
   parameter bit LOCK_EN     = 1'b1,
   parameter int SYNC_STAGES = 2,
   localparam int CH_W       = $clog2(NUM_CH),
   localparam int SYNC_W     = NUM_CH + NUM_KEY
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_CH-1:0]        pin_i,
   input  logic [NUM_KEY-1:0]       key_i,
   input  logic                     unlock_i,
   input  logic                     wr_en_i,
   input  logic [CH_W-1:0]          wr_ch_i,
   input  logic [CTRL_W-1:0]        wr_data_i,
   output logic [NUM_CH-1:0]        set_req_o,
   output logic [CTRL_W*NUM_CH-1:0] ctrl_rd_o
);
   if (NUM_CH < 2 || KEY_CH >= NUM_CH || LOCK_CH >= NUM_CH) begin : g_bad_ch
      $error("ext_irq_cond: channel parameters out of range");
   end
   if (KEY_NARROW < 1 || KEY_NARROW > NUM_KEY) begin : g_bad_key
      $error("ext_irq_cond: KEY_NARROW must lie in 1..NUM_KEY");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ext_irq_cond: at least two synchronizer stages required");
   end

   logic [CTRL_W-1:0] ctrl_q [NUM_CH];
   logic [NUM_CH-1:0] pin_s;
   logic [NUM_KEY-1:0] key_s;

   ext_irq_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) sync_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({key_i, pin_i}),
      .sync_o  ({key_s, pin_s})
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic wr_ok;
      if (LOCK_EN && c == LOCK_CH) begin : g_locked
         assign wr_ok = unlock_i;
      end else begin : g_open
         assign wr_ok = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ctrl_q[c] <= '0;
         else if (wr_en_i && (int'(wr_ch_i) == c) && wr_ok)
            ctrl_q[c] <= wr_data_i;
      end

      assign ctrl_rd_o[c*CTRL_W +: CTRL_W] = ctrl_q[c];

      if (c == KEY_CH) begin : g_key_ch
         logic [NUM_KEY:0] mask;
         ext_irq_keysel #(.NUM_KEY(NUM_KEY), .KEY_NARROW(KEY_NARROW)) keysel_i (
            .sel_i  (src_sel_e'(ctrl_q[c][SRC_HI:SRC_LO])),
            .mask_o (mask)
         );
         ext_irq_detect #(.W(NUM_KEY+1)) det_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   ({key_s, pin_s[c]}),
            .mask_i (mask),
            .pol_i  (ctrl_q[c][POL_BIT]),
            .lvl_i  (ctrl_q[c][LVL_BIT]),
            .req_o  (set_req_o[c])
         );
      end else begin : g_pin_ch
         ext_irq_detect #(.W(1)) det_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_i   (pin_s[c]),
            .mask_i (1'b1),
            .pol_i  (ctrl_q[c][POL_BIT]),
            .lvl_i  (ctrl_q[c][LVL_BIT]),
            .req_o  (set_req_o[c])
         );
      end
   end

   // R8: reserved source code silences the key channel
   a_r8_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[KEY_CH][SRC_HI:SRC_LO] == SRC_RSVD) |-> !set_req_o[KEY_CH]);

   // R2: out-of-range channel writes leave every register untouched
   a_r2_range_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && int'(wr_ch_i) >= NUM_CH) |=> $stable(ctrl_rd_o));

   if (LOCK_EN) begin : g_lock_chk
      // R9: locked register holds while unlock is low
      a_r9_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en_i && !unlock_i && int'(wr_ch_i) == LOCK_CH) |=> $stable(ctrl_q[LOCK_CH]));
   end
endmodule

// File: tb/ext_irq_cond_tb.sv
module ext_irq_cond_tb_top;
   localparam int CLK_P   = 10;
   localparam int NUM_CH  = 5;
   localparam int NUM_KEY = 5;
   localparam int NVEC    = 8;

   // {ch[14:12], ctrl[11:4], pin_before[3], pin_after[2], exp_first[1], exp_second[0]}
   localparam logic [14:0] VEC [NVEC] = '{
      {3'd0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0},
      {3'd0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0},
      {3'd1, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0},
      {3'd1, 8'h10, 1'b1, 1'b0, 1'b0, 1'b0},
      {3'd2, 8'h20, 1'b0, 1'b1, 1'b1, 1'b1},
      {3'd2, 8'h30, 1'b1, 1'b0, 1'b1, 1'b1},
      {3'd0, 8'h30, 1'b0, 1'b1, 1'b0, 1'b0},
      {3'd1, 8'h20, 1'b1, 1'b0, 1'b0, 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NUM_CH-1:0]  pin = '0;
   logic [NUM_KEY-1:0] key = '1;
   logic unlock = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_ch = '0;
   logic [7:0] wr_data = '0;
   logic [NUM_CH-1:0] set_req;
   logic [8*NUM_CH-1:0] ctrl_rd;

   int checks = 0;
   int failures = 0;

   always #(CLK_P/2) clk = ~clk;

   ext_irq_cond dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin),
      .key_i     (key),
      .unlock_i  (unlock),
      .wr_en_i   (wr_en),
      .wr_ch_i   (wr_ch),
      .wr_data_i (wr_data),
      .set_req_o (set_req),
      .ctrl_rd_o (ctrl_rd)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_ctrl(input logic [2:0] ch, input logic [7:0] d);
      wr_en = 1'b1; wr_ch = ch; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(1);
      check("R1 reset ctrl", 64'(ctrl_rd), 64'h0);
      check("R1 reset req", 64'(set_req), 64'h0);

      // vector table: polarity and mode combinations on pins 0..2
      for (int v = 0; v < NVEC; v++) begin
         logic [2:0] ch;
         logic [7:0] cv;
         logic pre;
         ch = VEC[v][14:12];
         cv = VEC[v][11:4];
         write_ctrl(ch, cv);
         pin[ch] = VEC[v][3];
         step(4);
         pre = cv[5] ? (cv[4] ? ~VEC[v][3] : VEC[v][3]) : 1'b0;
         pin[ch] = VEC[v][2];
         step(1);
         check($sformatf("R5 vec%0d one edge", v), 64'(set_req[ch]), 64'(pre));
         step(1);
         check($sformatf("R3/R4 vec%0d first", v), 64'(set_req[ch]), 64'(VEC[v][1]));
         step(1);
         check($sformatf("R3/R4 vec%0d second", v), 64'(set_req[ch]), 64'(VEC[v][0]));
      end

      // R3: level request held over many cycles
      write_ctrl(3'd0, 8'h20);
      pin[0] = 1'b1;
      step(2);
      for (int i = 0; i < 5; i++) begin
         check($sformatf("R3 level repeat %0d", i), 64'(set_req[0]), 64'h1);
         step(1);
      end
      pin[0] = 1'b0;

      // R2: readback and out-of-range write
      write_ctrl(3'd1, 8'h5A);
      check("R2 readback ch1", 64'(ctrl_rd[15:8]), 64'h5A);
      begin
         logic [8*NUM_CH-1:0] snap;
         snap = ctrl_rd;
         write_ctrl(3'd7, 8'hFF);
         check("R2 range write ignored", 64'(ctrl_rd), 64'(snap));
      end

      // R6/R7: key channel, level, active low, narrow group
      key = '1; pin[3] = 1'b0;
      write_ctrl(3'd3, 8'hB0);
      step(3);
      check("R6 keys idle", 64'(set_req[3]), 64'h0);
      key[2] = 1'b0;
      step(2);
      check("R7 one key active", 64'(set_req[3]), 64'h1);
      key[2] = 1'b1; key[4] = 1'b0;
      step(3);
      check("R6 key4 outside narrow", 64'(set_req[3]), 64'h0);
      write_ctrl(3'd3, 8'hF0);
      check("R6 key4 in wide", 64'(set_req[3]), 64'h1);

      // R8: reserved code
      key[0] = 1'b0;
      write_ctrl(3'd3, 8'h70);
      step(3);
      check("R8 reserved silent", 64'(set_req[3]), 64'h0);

      // R6: own pin source, keys ignored
      write_ctrl(3'd3, 8'h30);
      check("R6 own pin active", 64'(set_req[3]), 64'h1);
      pin[3] = 1'b1;
      step(3);
      check("R6 keys ignored on pin source", 64'(set_req[3]), 64'h0);

      // R7/R4: key edge mode, falling edge on any key
      key = '1;
      write_ctrl(3'd3, 8'h80);
      step(3);
      key[1] = 1'b0;
      step(2);
      check("R7 key edge pulse", 64'(set_req[3]), 64'h1);
      step(1);
      check("R4 key edge single", 64'(set_req[3]), 64'h0);

      // R9: locked register
      unlock = 1'b0;
      write_ctrl(3'd4, 8'h33);
      check("R9 locked write ignored", 64'(ctrl_rd[39:32]), 64'h00);
      unlock = 1'b1;
      write_ctrl(3'd4, 8'h33);
      check("R9 unlocked write", 64'(ctrl_rd[39:32]), 64'h33);
      unlock = 1'b0;
      write_ctrl(3'd4, 8'h11);
      check("R9 relocked hold", 64'(ctrl_rd[39:32]), 64'h33);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule